// File: doc/BRIEF.md
# Master Video Sync Generator

This block produces the horizontal sync, vertical sync and field-parity timing for a video encoder that acts as the timing master. It runs from a 13.5 MHz sample clock and counts samples within a line and lines within a frame for either the 525-line system (858 samples per line) or the 625-line system (864 samples per line). The line and sample counts are brought out so that neighbouring logic can place active video, blanking and ancillary data.

The falling edge of the active-low horizontal sync tells an upstream decoder when to start sending pixel data. Its position is set by a 10-bit offset, supplied as a 2-bit upper byte and an 8-bit lower byte. The reset default of 0x07E places the falling edge on the first Cb sample of active video in the 525-line system. A smaller offset moves the pulse earlier. Because the offset range wraps across the line boundary, a pulse that starts near the end of a line is cut short at that boundary. A new offset is picked up only at a line start, so a pulse is never split or doubled.

The vertical sync marks the field sync datum of each field, and the field flag changes together with it. A synchronous active-low reset starts the generator at the first sample of a fixed line (254 for 525 lines, 301 for 625 lines), with the standard select captured while reset is held.

Top module: `sync_master_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the block loads line_num = 254 (std_pal = 0) or 301 (std_pal = 1), sample_num = 0, field = 0 and vs_n = 1, and it holds these values in the first cycle after release.
- R2: sample_num counts 0 to L-1 and then returns to 0, with L = 858 for std_pal = 0 and L = 864 for std_pal = 1. line_num rises by one at each such return and goes from 525 (or 625) back to 1.
- R3: The offset is O = {hoff_hi, hoff_lo} (hoff_hi holds bits 9:8). hs_n goes low at sample P = (O' - 6) mod L, where O' = O - L if O >= L and O' = O otherwise. The default 0x07E gives P = 120, the first Cb sample of a 525-line line.
- R4: hs_n stays low for 64 samples when P <= L-64. Otherwise it stays low for L-P samples and rises at sample 0 of the next line.
- R5: An offset change made during a line has no effect on the HS position of that line. It takes effect from the next sample 0.
- R6: std_pal is sampled only while rst_n is low. A change after release does not alter the line length or the line count until the next reset.
- R7: vs_n goes low for 3·L samples starting at the field-1 datum (525: line 4, sample 0; 625: line 1, sample 0) and at the field-2 datum (525: line 266, sample 429; 625: line 313, sample 432).
- R8: field is 0 from the field-1 datum up to the field-2 datum and 1 for the rest of the frame. It changes only on the cycle where vs_n falls.
- R9: Offsets at or above the line length are reduced by one line length before use. For example, 1000 in the 525-line system places the HS fall at sample 136.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| std_pal | input | 1 | Standard select: 0 = 525 lines / 858 samples, 1 = 625 lines / 864 samples |
| hoff_hi | input | 2 | HS offset, bits 9:8 |
| hoff_lo | input | 8 | HS offset, bits 7:0 |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| field | output | 1 | Field parity, 0 = first field |
| line_num | output | 10 | Current line, 1-based |
| sample_num | output | 10 | Current sample within the line, 0-based |

## Verification
The bench targets the offsets that put the HS fall within 64 samples of the line end in both standards: the one-sample pulse at P = L-1 and a pulse truncated partway. A design that let these pulses run into the next line would report widths above the expected value. It also checks offsets at or above the line length and the zero-delay default, where an off-by-one in the modulo arithmetic would move the fall by one or six samples. It changes the offset in the middle of a line and flips the standard select after reset; a design that applied either immediately would move the HS in the current line or change the line length. Finally it runs through the frame wrap and both field datums, so a wrong half-line datum or a field flag that moves independently of VS would show up as a wrong line, sample or parity.

// File: rtl/sync_gen_pkg.sv
// Package: sync_gen_pkg
// Shared encodings for the master sync generator.
// Assumes: standard select is a single bit, 0 = 525-line system.
package sync_gen_pkg;
    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } video_std_e;
endpackage

// File: rtl/sync_std_cfg.sv
// Module: sync_std_cfg
// Captures the standard select during reset and turns it into line length,
// frame size, reset position and field datum constants for the timebase.
// While reset is held the live select drives the outputs, so the reset
// values loaded elsewhere already match the chosen standard.
// Assumes: all parameters fit the widths passed in (checked by the top).
module sync_std_cfg
    import sync_gen_pkg::*;
#(
    parameter int L525 = 858,
    parameter int L625 = 864,
    parameter int N525 = 525,
    parameter int N625 = 625,
    parameter int RST_LINE_525 = 254,
    parameter int RST_LINE_625 = 301,
    parameter int F1_LINE_525 = 4,
    parameter int F2_LINE_525 = 266,
    parameter int F1_LINE_625 = 1,
    parameter int F2_LINE_625 = 313,
    parameter int VS_LINES = 3,
    parameter int HW = 10,
    parameter int VW = 10,
    parameter int FW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          std_pal,
    output logic [HW:0]   line_len,
    output logic [HW-1:0] line_last,
    output logic [VW-1:0] lines,
    output logic [VW-1:0] rst_line,
    output logic [FW-1:0] rst_pos,
    output logic [FW-1:0] frame_last,
    output logic [FW-1:0] datum1,
    output logic [FW-1:0] datum2,
    output logic [FW-1:0] vs_len
);
    localparam logic [FW-1:0] RPOS_A = FW'((RST_LINE_525 - 1) * L525);
    localparam logic [FW-1:0] RPOS_B = FW'((RST_LINE_625 - 1) * L625);
    localparam logic [FW-1:0] FLAST_A = FW'(N525 * L525 - 1);
    localparam logic [FW-1:0] FLAST_B = FW'(N625 * L625 - 1);
    localparam logic [FW-1:0] D1_A = FW'((F1_LINE_525 - 1) * L525);
    localparam logic [FW-1:0] D1_B = FW'((F1_LINE_625 - 1) * L625);
    localparam logic [FW-1:0] D2_A = FW'((F2_LINE_525 - 1) * L525 + L525 / 2);
    localparam logic [FW-1:0] D2_B = FW'((F2_LINE_625 - 1) * L625 + L625 / 2);
    localparam logic [FW-1:0] VLEN_A = FW'(VS_LINES * L525);
    localparam logic [FW-1:0] VLEN_B = FW'(VS_LINES * L625);

    video_std_e std_q;
    video_std_e std_sel;

    // Hold the standard captured during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) std_q <= video_std_e'(std_pal);
    end

    // Live select during reset, captured select afterwards.
    assign std_sel = rst_n ? std_q : video_std_e'(std_pal);

    // Map the selected standard onto its timing constants.
    always_comb begin
        if (std_sel == STD_625) begin
            line_len   = (HW+1)'(L625);
            line_last  = HW'(L625 - 1);
            lines      = VW'(N625);
            rst_line   = VW'(RST_LINE_625);
            rst_pos    = RPOS_B;
            frame_last = FLAST_B;
            datum1     = D1_B;
            datum2     = D2_B;
            vs_len     = VLEN_B;
        end else begin
            line_len   = (HW+1)'(L525);
            line_last  = HW'(L525 - 1);
            lines      = VW'(N525);
            rst_line   = VW'(RST_LINE_525);
            rst_pos    = RPOS_A;
            frame_last = FLAST_A;
            datum1     = D1_A;
            datum2     = D2_A;
            vs_len     = VLEN_A;
        end
    end
endmodule

// File: rtl/sync_timebase.sv
// Module: sync_timebase
// Sample, line and frame-position counters. The frame position is kept as
// its own counter so that field decoding needs no multiplier.
// Assumes: rst_pos equals (rst_line-1) times the line length.
module sync_timebase #(
    parameter int HW = 10,
    parameter int VW = 10,
    parameter int FW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] line_last,
    input  logic [VW-1:0] lines,
    input  logic [VW-1:0] rst_line,
    input  logic [FW-1:0] rst_pos,
    input  logic [FW-1:0] frame_last,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic [FW-1:0] fpos,
    output logic          line_end
);
    assign line_end = (hcnt == line_last);

    // Sample counter within the line.
    always_ff @(posedge clk) begin
        if (!rst_n)        hcnt <= '0;
        else if (line_end) hcnt <= '0;
        else               hcnt <= hcnt + 1'b1;
    end

    // 1-based line counter, wraps after the last line of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         vcnt <= rst_line;
        else if (line_end)  vcnt <= (vcnt == lines) ? VW'(1) : vcnt + 1'b1;
    end

    // Sample position within the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                   fpos <= rst_pos;
        else if (fpos == frame_last)  fpos <= '0;
        else                          fpos <= fpos + 1'b1;
    end
endmodule

// File: rtl/sync_hs_gen.sv
// Module: sync_hs_gen
// Converts the 10-bit offset into an HS fall position and drives the
// active-low HS pulse. The position is latched in reset and at each line
// end, so it only changes from sample 0. A pulse that starts late in the
// line ends with the line because the sample counter never passes L-1.
// Assumes: offset < 2 * line length, offset width <= HW+1.
module sync_hs_gen #(
    parameter int HW = 10,
    parameter int OFF_W = 10,
    parameter int HS_WIDTH = 64,
    parameter int HS_BIAS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic [HW-1:0]    hcnt,
    input  logic [HW:0]      line_len,
    input  logic [OFF_W-1:0] offset,
    output logic             hs_n
);
    localparam int AW = HW + 2;

    logic [AW-1:0] off_w;
    logic [AW-1:0] len_w;
    logic [AW-1:0] eff;
    logic [AW-1:0] pos_nxt;
    logic [AW-1:0] pos_q;
    logic [AW-1:0] h_w;

    assign off_w = AW'(offset);
    assign len_w = AW'(line_len);
    assign h_w   = AW'(hcnt);

    // Fold the offset into one line, then shift by the fixed bias modulo L.
    always_comb begin
        eff = (off_w >= len_w) ? off_w - len_w : off_w;
        if (eff >= AW'(HS_BIAS)) pos_nxt = eff - AW'(HS_BIAS);
        else                     pos_nxt = eff + len_w - AW'(HS_BIAS);
    end

    // Take a new fall position only at reset or at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n || line_end) pos_q <= pos_nxt;
    end

    // HS is low from the fall position for the pulse width or to line end.
    assign hs_n = !((h_w >= pos_q) && (h_w < pos_q + AW'(HS_WIDTH)));
endmodule

// File: rtl/sync_vfield_gen.sv
// Module: sync_vfield_gen
// Decodes VS and field parity from the frame position. Each field datum
// opens a VS window of vs_len samples; parity is 0 between the first and
// second datum.
// Assumes: datum1 < datum2 and both windows end inside the frame.
module sync_vfield_gen #(
    parameter int FW = 20
) (
    input  logic [FW-1:0] fpos,
    input  logic [FW-1:0] datum1,
    input  logic [FW-1:0] datum2,
    input  logic [FW-1:0] vs_len,
    output logic          vs_n,
    output logic          field
);
    logic [1:0]    in_win;
    logic [FW-1:0] starts [2];

    assign starts[0] = datum1;
    assign starts[1] = datum2;

    // One VS window comparator per field datum.
    for (genvar f = 0; f < 2; f++) begin : g_win
        assign in_win[f] = (fpos >= starts[f]) && (fpos < starts[f] + vs_len);
    end

    // VS is active in either window.
    assign vs_n = ~|in_win;

    // Parity: second field outside the first-to-second datum span.
    assign field = !((fpos >= datum1) && (fpos < datum2));
endmodule

// File: rtl/sync_master_gen.sv
// Module: sync_master_gen (top)
// Master-mode HS/VS/field generator for 525- and 625-line video from a
// 13.5 MHz sample clock. Wires the standard config, timebase, HS and
// VS/field units together.
// Assumes: synchronous active-low reset held for at least one clock edge.
module sync_master_gen #(
    parameter int L525 = 858,
    parameter int L625 = 864,
    parameter int N525 = 525,
    parameter int N625 = 625,
    parameter int RST_LINE_525 = 254,
    parameter int RST_LINE_625 = 301,
    parameter int F1_LINE_525 = 4,
    parameter int F2_LINE_525 = 266,
    parameter int F1_LINE_625 = 1,
    parameter int F2_LINE_625 = 313,
    parameter int VS_LINES = 3,
    parameter int HS_WIDTH = 64,
    parameter int HS_BIAS = 6,
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             std_pal,
    input  logic [OFF_W-9:0] hoff_hi,
    input  logic [7:0]       hoff_lo,
    output logic             hs_n,
    output logic             vs_n,
    output logic             field,
    output logic [9:0]       line_num,
    output logic [9:0]       sample_num
);
    localparam int LMAX = (L625 > L525) ? L625 : L525;
    localparam int NMAX = (N625 > N525) ? N625 : N525;
    localparam int HW   = $clog2(LMAX);
    localparam int VW   = $clog2(NMAX + 1);
    localparam int FW   = $clog2(LMAX * NMAX);

    logic [HW:0]    line_len;
    logic [HW-1:0]  line_last;
    logic [VW-1:0]  lines;
    logic [VW-1:0]  rst_line;
    logic [FW-1:0]  rst_pos;
    logic [FW-1:0]  frame_last;
    logic [FW-1:0]  datum1;
    logic [FW-1:0]  datum2;
    logic [FW-1:0]  vs_len;
    logic [HW-1:0]  hcnt;
    logic [VW-1:0]  vcnt;
    logic [FW-1:0]  fpos;
    logic           line_end;

    sync_std_cfg #(
        .L525(L525), .L625(L625), .N525(N525), .N625(N625),
        .RST_LINE_525(RST_LINE_525), .RST_LINE_625(RST_LINE_625),
        .F1_LINE_525(F1_LINE_525), .F2_LINE_525(F2_LINE_525),
        .F1_LINE_625(F1_LINE_625), .F2_LINE_625(F2_LINE_625),
        .VS_LINES(VS_LINES), .HW(HW), .VW(VW), .FW(FW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .std_pal(std_pal),
        .line_len(line_len), .line_last(line_last), .lines(lines),
        .rst_line(rst_line), .rst_pos(rst_pos), .frame_last(frame_last),
        .datum1(datum1), .datum2(datum2), .vs_len(vs_len)
    );

    sync_timebase #(.HW(HW), .VW(VW), .FW(FW)) u_tb (
        .clk(clk), .rst_n(rst_n), .line_last(line_last), .lines(lines),
        .rst_line(rst_line), .rst_pos(rst_pos), .frame_last(frame_last),
        .hcnt(hcnt), .vcnt(vcnt), .fpos(fpos), .line_end(line_end)
    );

    sync_hs_gen #(
        .HW(HW), .OFF_W(OFF_W), .HS_WIDTH(HS_WIDTH), .HS_BIAS(HS_BIAS)
    ) u_hs (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .hcnt(hcnt),
        .line_len(line_len), .offset({hoff_hi, hoff_lo}), .hs_n(hs_n)
    );

    sync_vfield_gen #(.FW(FW)) u_vf (
        .fpos(fpos), .datum1(datum1), .datum2(datum2), .vs_len(vs_len),
        .vs_n(vs_n), .field(field)
    );

    assign line_num   = 10'(vcnt);
    assign sample_num = 10'(hcnt);
endmodule

// File: rtl/sync_master_gen_chk.sv
// Module: sync_master_gen_chk
// Port-level temporal checks for sync_master_gen, bound into every instance.
module sync_master_gen_chk #(
    parameter int L525 = 858,
    parameter int L625 = 864,
    parameter int N525 = 525,
    parameter int N625 = 625,
    parameter int RST_LINE_525 = 254,
    parameter int RST_LINE_625 = 301,
    parameter int HS_WIDTH = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       std_pal,
    input logic       hs_n,
    input logic       vs_n,
    input logic       field,
    input logic [9:0] line_num,
    input logic [9:0] sample_num
);
    logic       std_q;
    logic [9:0] lm1;
    logic [9:0] nl;
    logic [9:0] rl;
    logic [7:0] low_run;

    // Standard as seen during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) std_q <= std_pal;
    end

    assign lm1 = std_q ? 10'(L625 - 1) : 10'(L525 - 1);
    assign nl  = std_q ? 10'(N625) : 10'(N525);
    assign rl  = std_q ? 10'(RST_LINE_625) : 10'(RST_LINE_525);

    // Length of the HS low run within the current line, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_run <= '0;
        else if (hs_n)             low_run <= '0;
        else if (sample_num == '0) low_run <= 8'd1;
        else if (low_run != '1)    low_run <= low_run + 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (line_num == rl && sample_num == '0 && !field && vs_n));

    p_sample_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_num == lm1) |=> (sample_num == '0));

    p_sample_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_num != lm1) |=> (sample_num == $past(sample_num) + 10'd1));

    p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_num == lm1) |=>
        (line_num == (($past(line_num) == nl) ? 10'd1 : $past(line_num) + 10'd1)));

    p_sample_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_num <= lm1);

    p_hs_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 8'(HS_WIDTH));

    p_field_on_vs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_n) |-> (field != $past(field)));

    p_field_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(vs_n) |-> $stable(field));
endmodule

bind sync_master_gen sync_master_gen_chk #(
    .L525(L525), .L625(L625), .N525(N525), .N625(N625),
    .RST_LINE_525(RST_LINE_525), .RST_LINE_625(RST_LINE_625),
    .HS_WIDTH(HS_WIDTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .hs_n(hs_n), .vs_n(vs_n),
    .field(field), .line_num(line_num), .sample_num(sample_num)
);

// File: tb/sync_master_gen_tb_top.sv
// Directed bench for sync_master_gen: one task per scenario.
module sync_master_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_pal = 1'b0;
    logic [1:0] hoff_hi = 2'h0;
    logic [7:0] hoff_lo = 8'h7E;
    logic       hs_n, vs_n, field;
    logic [9:0] line_num, sample_num;

    logic       rst_s_n = 1'b0;
    logic       hs_s_n, vs_s_n, field_s;
    logic [9:0] line_s, samp_s;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sync_master_gen dut_i (
        .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .hoff_hi(hoff_hi),
        .hoff_lo(hoff_lo), .hs_n(hs_n), .vs_n(vs_n), .field(field),
        .line_num(line_num), .sample_num(sample_num)
    );

    // Short-frame instance to reach the frame wrap and field-1 datum quickly.
    sync_master_gen #(.N525(30), .RST_LINE_525(10), .F2_LINE_525(20)) dut_small_i (
        .clk(clk), .rst_n(rst_s_n), .std_pal(1'b0), .hoff_hi(2'h0),
        .hoff_lo(8'h7E), .hs_n(hs_s_n), .vs_n(vs_s_n), .field(field_s),
        .line_num(line_s), .sample_num(samp_s)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic pal);
        @(negedge clk);
        rst_n = 1'b0;
        std_pal = pal;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a new offset, then move to sample 0 of the first line using it.
    task automatic apply_off(input int v, input int len);
        @(negedge clk);
        {hoff_hi, hoff_lo} = 10'(v);
        while (sample_num != 10'(len - 1)) @(negedge clk);
        @(negedge clk);
    endtask

    // Find the next HS fall and measure its low length.
    task automatic meas_hs(output int fall_s, output int width);
        logic prev;
        prev = hs_n;
        forever begin
            @(negedge clk);
            if (prev && !hs_n) break;
            prev = hs_n;
        end
        fall_s = int'(sample_num);
        width = 0;
        while (!hs_n) begin
            width++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        chk("R1", "525 reset line", int'(line_num), 254);
        chk("R1", "525 reset sample", int'(sample_num), 0);
        chk("R1", "525 reset field", int'(field), 0);
        chk("R1", "525 reset vs_n", int'(vs_n), 1);
        do_reset(1'b1);
        chk("R1", "625 reset line", int'(line_num), 301);
        chk("R1", "625 reset sample", int'(sample_num), 0);
    endtask

    task automatic t_line_length();
        int ln;
        do_reset(1'b1);
        while (sample_num != 10'd863) @(negedge clk);
        ln = int'(line_num);
        @(negedge clk);
        chk("R2", "625 sample wrap", int'(sample_num), 0);
        chk("R2", "625 line step", int'(line_num), ln + 1);
    endtask

    task automatic t_std_ignored();
        int ln;
        do_reset(1'b0);
        @(negedge clk);
        std_pal = 1'b1;
        while (sample_num != 10'd857) @(negedge clk);
        ln = int'(line_num);
        @(negedge clk);
        chk("R6", "525 length kept after std flip", int'(sample_num), 0);
        chk("R6", "line step after std flip", int'(line_num), ln + 1);
        std_pal = 1'b0;
    endtask

    task automatic t_hs_525();
        int f, w;
        {hoff_hi, hoff_lo} = 10'h07E;
        do_reset(1'b0);
        meas_hs(f, w);
        chk("R3", "default fall", f, 120);
        chk("R4", "default width", w, 64);
        apply_off(830, 858);
        meas_hs(f, w);
        chk("R3", "off 830 fall", f, 824);
        chk("R4", "off 830 truncated width", w, 34);
        apply_off(863, 858);
        meas_hs(f, w);
        chk("R3", "off 863 fall", f, 857);
        chk("R4", "off 863 one-sample width", w, 1);
        apply_off(1000, 858);
        meas_hs(f, w);
        chk("R9", "off 1000 folded fall", f, 136);
        chk("R4", "off 1000 width", w, 64);
    endtask

    task automatic t_hs_625();
        int f, w;
        do_reset(1'b1);
        apply_off(6, 864);
        meas_hs(f, w);
        chk("R3", "625 off 6 fall", f, 0);
        chk("R4", "625 off 6 width", w, 64);
        apply_off(137, 864);
        meas_hs(f, w);
        chk("R3", "625 off 137 fall", f, 131);
        apply_off(869, 864);
        meas_hs(f, w);
        chk("R3", "625 off 869 fall", f, 863);
        chk("R4", "625 off 869 width", w, 1);
    endtask

    task automatic t_midline_change();
        int f, w;
        do_reset(1'b0);
        apply_off(126, 858);
        while (sample_num != 10'd50) @(negedge clk);
        {hoff_hi, hoff_lo} = 10'd300;
        meas_hs(f, w);
        chk("R5", "current line keeps old fall", f, 120);
        meas_hs(f, w);
        chk("R5", "next line uses new fall", f, 294);
        chk("R4", "new offset width", w, 64);
    endtask

    task automatic t_vs_field2(input logic pal, input int exp_line, input int exp_samp, input int len);
        int w;
        logic fb;
        {hoff_hi, hoff_lo} = 10'h07E;
        do_reset(pal);
        fb = field;
        while (vs_n) begin
            fb = field;
            @(negedge clk);
        end
        chk("R7", "field-2 VS line", int'(line_num), exp_line);
        chk("R7", "field-2 VS sample", int'(sample_num), exp_samp);
        chk("R8", "field before datum 2", int'(fb), 0);
        chk("R8", "field at datum 2", int'(field), 1);
        w = 0;
        while (!vs_n) begin
            w++;
            @(negedge clk);
        end
        chk("R7", "field-2 VS width", w, 3 * len);
    endtask

    task automatic t_frame_wrap_small();
        logic fb;
        @(negedge clk);
        rst_s_n = 1'b1;
        while (!(line_s == 10'd30 && samp_s == 10'd857)) @(negedge clk);
        @(negedge clk);
        chk("R2", "frame wrap line", int'(line_s), 1);
        chk("R2", "frame wrap sample", int'(samp_s), 0);
        fb = field_s;
        while (vs_s_n) begin
            fb = field_s;
            @(negedge clk);
        end
        chk("R7", "field-1 VS line", int'(line_s), 4);
        chk("R7", "field-1 VS sample", int'(samp_s), 0);
        chk("R8", "field before datum 1", int'(fb), 1);
        chk("R8", "field at datum 1", int'(field_s), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 190000 cycles expected completion earlier");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_line_length();
        t_std_ignored();
        t_hs_525();
        t_hs_625();
        t_midline_change();
        t_vs_field2(1'b0, 266, 429, 858);
        t_vs_field2(1'b1, 313, 432, 864);
        t_frame_wrap_small();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule